// File: doc/BRIEF.md
# Four-Channel Single-Transfer DMA Controller

This block moves data between memory and I/O devices without the host processor. A host programs each of four channels through a byte-wide register port. For each channel it sets a 16-bit start address, a 16-bit count, a page byte, a direction, an address step direction and an auto-reload option, and then unmasks the channel. A device raises its request line. The controller asks for the system bus, waits for the grant, and then runs exactly one transfer cycle. In that cycle it acknowledges the device, drives the memory address and pulses the strobes that match the channel's direction. It then releases the bus.

The count is written as the transfer length minus one. It steps down once per transfer, and terminal count is the step from 0 to 0xFFFF. On the last transfer the controller raises a terminal-count output and sets a sticky flag. It then either masks the channel or, with auto-reload, restores the programmed address and count. The page byte sits above the 16-bit address and is never changed by a carry, so every buffer stays inside one 64 KB window.

Top module: `dma4_ctrl`

## Requirements
- R1: The count register (port address 2n+1 for channel n) is written with length minus one; read back, it returns the remaining transfers minus one, reaching 0xFFFF after the last one.
- R2: The current address (port address 2n) steps by +1 after each transfer, or by -1 when the channel's mode bit 5 is set. `mem_addr` is {page, current address}, and a wrap of the low 16 bits leaves the page byte unchanged.
- R3: On the transfer whose count is 0, `tc_out` is high during the acknowledge cycle and the channel's terminal-count flag is set. Status (read at address 8) returns {request lines[3:0], flags[3:0]}, and that read clears the flags.
- R4: Without auto-reload, terminal count sets the channel's mask bit and leaves the current address one step past the last location used.
- R5: With auto-reload (mode bit 4), terminal count reloads the programmed address and count and leaves the mask bit clear, so later requests keep being served.
- R6: A masked channel's request is ignored. Address 9 sets (data bit 2 = 1) or clears (bit 2 = 0) the mask of the channel in data bits 1:0. Address 12 writes all four masks from data bits 3:0 and reads them back. All channels are masked after reset.
- R7: When several unmasked requests are pending, channel 0 wins over 1, 1 over 2, and 2 over 3.
- R8: Mode is written at address 10: channel in data bits 1:0, direction in bits 3:2. Direction 01 (I/O to memory) pulses `io_rd` and `mem_wr`. Direction 10 (memory to I/O) pulses `mem_rd` and `io_wr`. Direction 00 (verify) asserts no memory strobe and no I/O strobe.
- R9: A serviced request raises `hold_req`. The acknowledge is withheld until `hold_grant` is high and then lasts exactly one cycle. `hold_req` drops in the cycle after the acknowledge.
- R10: Each 16-bit register is accessed as two byte operations, low byte first. A shared byte pointer toggles on every access to addresses 0 to 7, and a write to address 11 resets it to the low byte.
- R11: The status request bits show the raw request lines, whether or not the channel is masked.
- R12: A write to a channel's address or count register clears that channel's terminal-count flag. The page is written at address 16+n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_rdata | output | 8 | Register read data |
| dreq | input | 4 | Device request lines |
| dack | output | 4 | Device acknowledge lines |
| hold_req | output | 1 | Bus request |
| hold_grant | input | 1 | Bus grant |
| mem_addr | output | 24 | Memory address {page, current address} |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| tc_out | output | 1 | Terminal count, during the last transfer |

## Verification
The assertions assume a well-behaved environment. A device drops its request once it sees its acknowledge, and the host does not write a channel's registers or masks in the cycle that channel is finishing a transfer. The bench keeps to both rules. Its device model clears each request on the acknowledge cycle, and register writes are issued only while no request is raised. Expected transfers, covering channel, full address, terminal count and strobes, are queued by the stimulus and compared as the acknowledges appear.

// File: rtl/dma4_ctrl.sv
module dma4_ctrl #(
  parameter int NCH = 4,
  parameter int PW  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [4:0]          reg_addr,
  input  logic [7:0]          reg_wdata,
  input  logic                reg_wr,
  input  logic                reg_rd,
  output logic [7:0]          reg_rdata,
  input  logic [NCH-1:0]      dreq,
  output logic [NCH-1:0]      dack,
  output logic                hold_req,
  input  logic                hold_grant,
  output logic [PW+15:0]      mem_addr,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic                io_rd,
  output logic                io_wr,
  output logic                tc_out
);
  localparam int AW = 16;
  localparam int CW = $clog2(NCH);
  localparam logic [1:0] D_TOMEM = 2'b01;
  localparam logic [1:0] D_FRMEM = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_XFER} st_t;

  st_t              state;
  logic [CW-1:0]    sel, pick;
  logic             found, ptr;
  logic [AW-1:0]    base_a [NCH];
  logic [AW-1:0]    base_c [NCH];
  logic [AW-1:0]    cur_a  [NCH];
  logic [AW-1:0]    cur_c  [NCH];
  logic [PW-1:0]    page   [NCH];
  logic [1:0]       dir    [NCH];
  logic [NCH-1:0]   auto_i, dec, mask, tc_flag;

  wire              xfer  = (state == S_XFER);
  wire              chreg = (reg_addr < 5'd8);
  wire [CW-1:0]     rch   = reg_addr[CW:1];
  wire [CW-1:0]     wch   = reg_wdata[CW-1:0];
  wire              last  = (cur_c[sel] == '0);
  wire [AW-1:0]     stepped = dec[sel] ? cur_a[sel] - 16'd1 : cur_a[sel] + 16'd1;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NCH-1; i >= 0; i--)
      if (dreq[i] && !mask[i]) begin
        found = 1'b1;
        pick  = CW'(i);
      end
  end

  assign hold_req = (state != S_IDLE);
  assign dack     = xfer ? (NCH'(1) << sel) : '0;
  assign mem_addr = {page[sel], cur_a[sel]};
  assign tc_out   = xfer && last;
  assign mem_wr   = xfer && (dir[sel] == D_TOMEM);
  assign io_rd    = xfer && (dir[sel] == D_TOMEM);
  assign mem_rd   = xfer && (dir[sel] == D_FRMEM);
  assign io_wr    = xfer && (dir[sel] == D_FRMEM);

  always_comb begin
    logic [AW-1:0] w;
    w = reg_addr[0] ? cur_c[rch] : cur_a[rch];
    reg_rdata = '0;
    if (chreg)                  reg_rdata = ptr ? w[15:8] : w[7:0];
    else if (reg_addr == 5'd8)  reg_rdata = 8'({dreq, tc_flag});
    else if (reg_addr == 5'd12) reg_rdata = 8'(mask);
    else if (reg_addr[4])       reg_rdata = 8'(page[reg_addr[CW-1:0]]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      sel     <= '0;
      ptr     <= 1'b0;
      auto_i  <= '0;
      dec     <= '0;
      mask    <= '1;
      tc_flag <= '0;
      for (int i = 0; i < NCH; i++) begin
        base_a[i] <= '0;
        base_c[i] <= '0;
        cur_a[i]  <= '0;
        cur_c[i]  <= '0;
        page[i]   <= '0;
        dir[i]    <= '0;
      end
    end else begin
      case (state)
        S_IDLE: if (found) begin
          sel   <= pick;
          state <= S_REQ;
        end
        S_REQ:  if (hold_grant) state <= S_XFER;
        default: state <= S_IDLE;
      endcase

      if ((reg_wr || reg_rd) && chreg) ptr <= ~ptr;
      if (reg_rd && reg_addr == 5'd8) tc_flag <= '0;

      if (reg_wr) begin
        if (chreg) begin
          tc_flag[rch] <= 1'b0;
          if (reg_addr[0]) begin
            if (ptr) begin
              base_c[rch][15:8] <= reg_wdata;
              cur_c[rch][15:8]  <= reg_wdata;
            end else begin
              base_c[rch][7:0] <= reg_wdata;
              cur_c[rch][7:0]  <= reg_wdata;
            end
          end else begin
            if (ptr) begin
              base_a[rch][15:8] <= reg_wdata;
              cur_a[rch][15:8]  <= reg_wdata;
            end else begin
              base_a[rch][7:0] <= reg_wdata;
              cur_a[rch][7:0]  <= reg_wdata;
            end
          end
        end else if (reg_addr[4]) begin
          page[reg_addr[CW-1:0]] <= PW'(reg_wdata);
        end else begin
          case (reg_addr)
            5'd9:  mask[wch] <= reg_wdata[2];
            5'd10: begin
              dir[wch]    <= reg_wdata[3:2];
              auto_i[wch] <= reg_wdata[4];
              dec[wch]    <= reg_wdata[5];
            end
            5'd11: ptr  <= 1'b0;
            5'd12: mask <= reg_wdata[NCH-1:0];
            default: ;
          endcase
        end
      end

      if (xfer) begin
        if (last) begin
          tc_flag[sel] <= 1'b1;
          if (auto_i[sel]) begin
            cur_c[sel] <= base_c[sel];
            cur_a[sel] <= base_a[sel];
          end else begin
            cur_c[sel] <= '1;
            cur_a[sel] <= stepped;
            mask[sel]  <= 1'b1;
          end
        end else begin
          cur_c[sel] <= cur_c[sel] - 16'd1;
          cur_a[sel] <= stepped;
        end
      end
    end
  end

  p_tc_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tc_out |=> (tc_flag & $past(dack)) != '0);

  p_self_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_out && !auto_i[sel]) |=> (mask & $past(dack)) != '0);

  p_reload_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_out && auto_i[sel] && !reg_wr) |=> (mask & $past(dack)) == '0);

  p_masked_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && (dreq & ~mask) == '0) |=> !hold_req);

  p_priority_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && dreq[0] && !mask[0]) |=> sel == '0);

  p_verify_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dack != '0 && dir[sel] == 2'b00) |-> !mem_rd && !mem_wr && !io_rd && !io_wr);

  p_wait_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_REQ && !hold_grant) |=> dack == '0);

  p_one_datum_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dack != '0) |=> dack == '0 && !hold_req);
endmodule

// File: tb/test_dma4_ctrl.sv
module test_dma4_ctrl;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [3:0]  ch;
    logic [23:0] addr;
    logic        tc;
    logic [3:0]  strb;
  } item_t;

  logic        clk = 0, rst_n = 0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_rdata;
  logic [3:0]  dreq = '0, dack;
  logic        hold_req, hold_grant = 0, grant_en = 1;
  logic [23:0] mem_addr;
  logic        mem_rd, mem_wr, io_rd, io_wr, tc_out;

  int nchecks = 0, nerr = 0;
  item_t expq[$];

  dma4_ctrl i_dma4_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .dreq(dreq),
    .dack(dack), .hold_req(hold_req), .hold_grant(hold_grant), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .tc_out(tc_out)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) hold_grant <= hold_req && grant_en;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && dack != '0) begin
    item_t got;
    got = '{ch: dack, addr: mem_addr, tc: tc_out, strb: {mem_rd, mem_wr, io_rd, io_wr}};
    if (expq.size() == 0) chk("R6 unexpected transfer", 32'(got.ch), 32'h0);
    else begin
      item_t e;
      e = expq.pop_front();
      chk("R2/R3/R7/R8 transfer ch", 32'(got.ch), 32'(e.ch));
      chk("R2 transfer addr", 32'(got.addr), 32'(e.addr));
      chk("R3 transfer tc", 32'(got.tc), 32'(e.tc));
      chk("R8 transfer strobes", 32'(got.strb), 32'(e.strb));
    end
  end

  task automatic push(input int ch, input logic [23:0] a, input logic tc, input logic [3:0] s);
    expq.push_back('{ch: 4'(1 << ch), addr: a, tc: tc, strb: s});
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wr16(input logic [4:0] a, input logic [15:0] d);
    wr(5'd11, 8'h00); wr(a, d[7:0]); wr(a, d[15:8]);
  endtask

  task automatic rd16(input logic [4:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    wr(5'd11, 8'h00); rd(a, lo); rd(a, hi); d = {hi, lo};
  endtask

  task automatic serve(input logic [3:0] m);
    logic [3:0] left;
    left = m;
    @(negedge clk); dreq = dreq | m;
    while (left != '0) begin
      @(negedge clk);
      left = left & ~dack;
      dreq = dreq & ~dack;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchecks++; nerr++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(5'd8, b);  chk("reset status R3", 32'(b), 32'h00);
    rd(5'd12, b); chk("reset masks R6", 32'(b), 32'h0F);

    // channel 2: I/O to memory, increment, no reload
    wr16(5'd4, 16'h1234); wr16(5'd5, 16'h0002); wr(5'd18, 8'h5A);
    wr(5'd10, 8'h06); wr(5'd9, 8'h02);
    rd16(5'd5, w); chk("R1 count readback", 32'(w), 32'h0002);
    push(2, 24'h5A1234, 0, 4'b0110); serve(4'b0100);
    rd16(5'd5, w); chk("R1 remaining after one", 32'(w), 32'h0001);
    push(2, 24'h5A1235, 0, 4'b0110); serve(4'b0100);
    push(2, 24'h5A1236, 1, 4'b0110); serve(4'b0100);
    rd16(5'd5, w); chk("R1 count underflow", 32'(w), 32'hFFFF);
    rd16(5'd4, w); chk("R4 address past end", 32'(w), 32'h1237);
    rd(5'd12, b);  chk("R4 self mask", 32'(b), 32'h0F);
    rd(5'd8, b);   chk("R3 tc flag set", 32'(b), 32'h04);
    rd(5'd8, b);   chk("R3 tc flag cleared by read", 32'(b), 32'h00);

    // R6 masked channel ignored, R11 raw request shown
    @(negedge clk); dreq[2] = 1;
    repeat (8) @(negedge clk);
    chk("R6 masked no hold", 32'(hold_req), 32'h0);
    rd(5'd8, b); chk("R11 request pending bit", 32'(b), 32'h40);
    @(negedge clk); dreq[2] = 0;

    // channel 1: memory to I/O, decrement, auto reload, wrap
    wr16(5'd2, 16'h0001); wr16(5'd3, 16'h0002); wr(5'd17, 8'h33);
    wr(5'd10, 8'h39); wr(5'd9, 8'h01);
    push(1, 24'h330001, 0, 4'b1001); serve(4'b0010);
    push(1, 24'h330000, 0, 4'b1001); serve(4'b0010);
    push(1, 24'h33FFFF, 1, 4'b1001); serve(4'b0010);
    rd(5'd12, b); chk("R5 mask stays clear", 32'(b), 32'h0D);
    push(1, 24'h330001, 0, 4'b1001); serve(4'b0010);
    rd16(5'd3, w); chk("R5 count reloaded", 32'(w), 32'h0001);
    rd16(5'd2, w); chk("R5 address reloaded and stepped", 32'(w), 32'h0000);
    rd(5'd8, b);   chk("R3 reload tc flag", 32'(b), 32'h02);

    // R7 priority with channel 0 in verify; R6 all-mask write
    wr16(5'd0, 16'h0100); wr16(5'd1, 16'h0005); wr(5'd10, 8'h00);
    wr(5'd12, 8'h0C);
    rd(5'd12, b); chk("R6 all-mask readback", 32'(b), 32'h0C);
    push(0, 24'h000100, 0, 4'b0000);
    push(1, 24'h330000, 0, 4'b1001);
    serve(4'b0011);

    // R12 base write clears tc flag
    push(1, 24'h33FFFF, 1, 4'b1001); serve(4'b0010);
    wr(5'd11, 8'h00); wr(5'd2, 8'h01);
    rd(5'd8, b); chk("R12 base write clears tc", 32'(b), 32'h00);

    // R9 bus handshake
    grant_en = 0;
    @(negedge clk); dreq[0] = 1;
    repeat (6) @(negedge clk);
    chk("R9 hold requested", 32'(hold_req), 32'h1);
    chk("R9 no ack before grant", 32'(dack), 32'h0);
    push(0, 24'h000101, 0, 4'b0000);
    grant_en = 1;
    serve(4'b0001);
    @(negedge clk); chk("R9 bus released", 32'(hold_req), 32'h0);

    // R10 byte pointer
    wr(5'd11, 8'h00); wr(5'd6, 8'hAA); wr(5'd11, 8'h00);
    wr(5'd6, 8'hBB); wr(5'd6, 8'hCC);
    rd16(5'd6, w); chk("R10 byte pointer order", 32'(w), 32'hCCBB);
    wr(5'd19, 8'h7E); rd(5'd19, b); chk("R12 page readback", 32'(b), 32'h7E);

    repeat (4) @(negedge clk);
    chk("scoreboard drained", 32'(expq.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule